// File: doc/BRIEF.md
# Two-Channel Interleave Mismatch Calibrator

This block removes the offset and gain mismatch left between the two halves of a two-way interleaved converter. It works in the background on the stream of signed samples that leaves the pipeline's error correction. Samples are numbered by arrival: the even-numbered ones form the reference virtual channel and go through untouched. The odd-numbered ones form the adjusted virtual channel. Each adjusted sample has an offset estimate subtracted and is then scaled by a fixed-point gain near unity.

The statistics that drive the two estimates come from the block's own output stream, split the same even/odd way. Over a block of 2^LOG2_BLK samples per channel, the calibrator sums each channel's samples and the magnitudes of those samples. A right shift turns the sums into a mean and a mean absolute value. At the end of each block the offset estimate moves by the mean difference and the gain estimate moves by the magnitude difference, each scaled down by a programmable shift. Clearing the enable input freezes both estimates.

Top module: `ilv_mismatch_cal`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, the offset estimate is 0 and the gain is unity (2^FRAC), so an adjusted sample leaves unchanged while no update has happened.
- R2: Only cycles with in_valid high advance the sample index. The first valid sample after reset is even (reference channel, tag 0) and the channels then alternate. A cycle with in_valid low produces out_valid low one cycle later.
- R3: A reference (even) sample appears unchanged on out_data with out_valid high exactly one clock after it is accepted.
- R4: An adjusted (odd) sample x leaves one clock later as floor(((x - off) * gain + 2^(FRAC-1)) / 2^FRAC), saturated to the DW-bit signed range. Here gain is unsigned with FRAC fraction bits.
- R5: The statistics are formed on the output stream. A block closes on the 2^LOG2_BLK-th adjusted output since the previous close. Each channel's mean is floor(sum / 2^LOG2_BLK) and its mean absolute value is floor(sum of |y| / 2^LOG2_BLK). Both sums restart from zero after a close.
- R6: At a block close with cal_en high, the offset becomes off + floor((mean_adj - mean_ref) / 2^off_shift), clamped to the DW-bit signed range.
- R7: At a block close with cal_en high, the gain becomes gain + floor((mav_ref - mav_adj) / 2^gain_shift), clamped to 0 .. 2^GW - 1.
- R8: While cal_en is low at a block close, both estimates keep their values, so the same input pair gives the same output before and after.
- R9: Estimates updated at a block close apply to every sample accepted from the following clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_en | input | 1 | High lets the estimates update at block closes |
| off_shift | input | SHW | Right shift that sets the offset loop step |
| gain_shift | input | SHW | Right shift that sets the gain loop step |
| in_valid | input | 1 | Input sample present |
| in_data | input | DW | Signed corrected input sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | DW | Signed calibrated output sample |

## Verification
The assertions assume that the stream always delivers samples as even/odd pairs, so the two channels accumulate the same number of samples in each block. They also assume that cal_en and the shift inputs change only between samples. The stimulus always sends whole pairs, inserts idle gaps only inside or between pairs, and changes the controls only while in_valid is low. The waveform amplitudes keep the mismatched channel inside full scale, except for a single deliberate probe that drives saturation.

// File: rtl/calib_pkg.sv
package calib_pkg;
    typedef enum logic {
        CH_REF = 1'b0,
        CH_ADJ = 1'b1
    } vchan_e;
endpackage

// File: rtl/ilv_corrector.sv
module ilv_corrector
    import calib_pkg::*;
#(
    parameter int DW   = 12,
    parameter int GW   = 14,
    parameter int FRAC = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic signed [DW-1:0] off_est,
    input  logic        [GW-1:0] gain_est,
    output logic                 out_valid,
    output vchan_e               out_chan,
    output logic signed [DW-1:0] out_data
);
    localparam int PW = DW + GW + 2;
    localparam logic signed [PW-1:0] HALF   = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] SAT_HI = PW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [PW-1:0] SAT_LO = -SAT_HI - PW'(1);

    typedef struct packed {
        logic                 tog;
        logic                 vld;
        vchan_e               ch;
        logic signed [DW-1:0] dat;
    } cor_t;

    cor_t q, d;
    logic signed [PW-1:0] x_w, o_w, g_w, prod, rnd;
    logic signed [DW-1:0] adj;

    always_comb begin
        x_w  = in_data;
        o_w  = off_est;
        g_w  = $signed({2'b00, gain_est});
        prod = (x_w - o_w) * g_w;
        rnd  = (prod + HALF) >>> FRAC;
        if (rnd > SAT_HI)      adj = SAT_HI[DW-1:0];
        else if (rnd < SAT_LO) adj = SAT_LO[DW-1:0];
        else                   adj = rnd[DW-1:0];

        d     = q;
        d.vld = in_valid;
        if (in_valid) begin
            d.tog = ~q.tog;
            d.ch  = q.tog ? CH_ADJ : CH_REF;
            d.dat = q.tog ? adj : in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{tog: 1'b0, vld: 1'b0, ch: CH_REF, dat: '0};
        else        q <= d;
    end

    assign out_valid = q.vld;
    assign out_chan  = q.ch;
    assign out_data  = q.dat;

    // R3: reference samples pass through with one cycle of latency
    p_ref_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !q.tog) |=> (out_valid && out_chan == CH_REF && out_data == $past(in_data)));

    // R2: no accepted sample, no output sample
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/ilv_stats.sv
module ilv_stats
    import calib_pkg::*;
#(
    parameter int DW       = 12,
    parameter int LOG2_BLK = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  vchan_e               s_chan,
    input  logic signed [DW-1:0] s_data,
    output logic                 blk_done,
    output logic signed [DW:0]   mean_ref,
    output logic signed [DW:0]   mean_adj,
    output logic signed [DW:0]   mav_ref,
    output logic signed [DW:0]   mav_adj
);
    localparam int SW = DW + LOG2_BLK + 1;
    localparam int AW = DW + LOG2_BLK;
    localparam int MW = DW + 1;

    typedef struct packed {
        logic signed [SW-1:0] sum;
        logic        [AW-1:0] mag;
    } acc_t;

    logic [LOG2_BLK-1:0] cnt_d, cnt_q;
    logic [DW-1:0]       absv;
    logic signed [MW-1:0] mean_a [2];
    logic signed [MW-1:0] mav_a  [2];

    assign absv     = (s_data < 0) ? DW'(-s_data) : DW'(s_data);
    assign blk_done = s_valid && (s_chan == CH_ADJ) && (&cnt_q);

    always_comb begin
        cnt_d = cnt_q;
        if (s_valid && s_chan == CH_ADJ) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        localparam vchan_e MY_CH = (ch == 0) ? CH_REF : CH_ADJ;
        acc_t acc_d, acc_q;
        logic signed [SW-1:0] tot_sum;
        logic        [AW-1:0] tot_mag;
        logic                 hit;

        always_comb begin
            hit     = s_valid && (s_chan == MY_CH);
            tot_sum = acc_q.sum + (hit ? SW'(s_data) : '0);
            tot_mag = acc_q.mag + (hit ? AW'(absv) : '0);
            mean_a[ch] = MW'(tot_sum >>> LOG2_BLK);
            mav_a[ch]  = $signed(MW'(tot_mag >> LOG2_BLK));
            if (blk_done) acc_d = '0;
            else          acc_d = '{sum: tot_sum, mag: tot_mag};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) acc_q <= '0;
            else        acc_q <= acc_d;
        end
    end

    assign mean_ref = mean_a[0];
    assign mean_adj = mean_a[1];
    assign mav_ref  = mav_a[0];
    assign mav_adj  = mav_a[1];

    // R5: every adjusted output advances the block position by one
    p_block_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_chan == CH_ADJ) |=> (cnt_q == LOG2_BLK'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/ilv_loop.sv
module ilv_loop #(
    parameter int DW   = 12,
    parameter int GW   = 14,
    parameter int FRAC = 12,
    parameter int SHW  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_en,
    input  logic [SHW-1:0]       off_shift,
    input  logic [SHW-1:0]       gain_shift,
    input  logic                 blk_done,
    input  logic signed [DW:0]   mean_ref,
    input  logic signed [DW:0]   mean_adj,
    input  logic signed [DW:0]   mav_ref,
    input  logic signed [DW:0]   mav_adj,
    output logic signed [DW-1:0] off_est,
    output logic        [GW-1:0] gain_est
);
    localparam int EW  = DW + 3;
    localparam int GSW = (GW + 2 > EW + 1) ? GW + 2 : EW + 1;
    localparam logic signed [EW-1:0]  OFF_HI = EW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [EW-1:0]  OFF_LO = -OFF_HI - EW'(1);
    localparam logic signed [GSW-1:0] G_MAX  = GSW'((1 <<< GW) - 1);
    localparam logic        [GW-1:0]  G_ONE  = GW'(1) << FRAC;

    typedef struct packed {
        logic signed [DW-1:0] off;
        logic        [GW-1:0] gain;
    } est_t;

    est_t q, d;
    logic signed [EW-1:0]  off_err, off_sum, g_err;
    logic signed [GSW-1:0] g_sum;

    always_comb begin
        off_err = EW'(mean_adj) - EW'(mean_ref);
        off_sum = EW'(q.off) + (off_err >>> off_shift);
        g_err   = EW'(mav_ref) - EW'(mav_adj);
        g_sum   = GSW'($signed({1'b0, q.gain})) + GSW'(g_err >>> gain_shift);

        d = q;
        if (blk_done && cal_en) begin
            if (off_sum > OFF_HI)      d.off = OFF_HI[DW-1:0];
            else if (off_sum < OFF_LO) d.off = OFF_LO[DW-1:0];
            else                       d.off = off_sum[DW-1:0];
            if (g_sum > G_MAX)         d.gain = G_MAX[GW-1:0];
            else if (g_sum < 0)        d.gain = '0;
            else                       d.gain = g_sum[GW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{off: '0, gain: G_ONE};
        else        q <= d;
    end

    assign off_est  = q.off;
    assign gain_est = q.gain;

    // R8: estimates move only at an enabled block close
    p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cal_en) || !$past(blk_done)) |-> ($stable(off_est) && $stable(gain_est)));

    // R6: a higher adjusted mean never lowers the offset estimate
    p_off_direction_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cal_en && blk_done) && $past(mean_adj) > $past(mean_ref)) |-> (off_est >= $past(off_est)));

    // R7: a larger reference magnitude never lowers the gain
    p_gain_direction_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cal_en && blk_done) && $past(mav_ref) > $past(mav_adj)) |-> (gain_est >= $past(gain_est)));
endmodule

// File: rtl/ilv_mismatch_cal.sv
module ilv_mismatch_cal
    import calib_pkg::*;
#(
    parameter int DW       = 12,
    parameter int GW       = 14,
    parameter int FRAC     = 12,
    parameter int LOG2_BLK = 12,
    parameter int SHW      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_en,
    input  logic [SHW-1:0]       off_shift,
    input  logic [SHW-1:0]       gain_shift,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    logic signed [DW-1:0] off_est;
    logic        [GW-1:0] gain_est;
    vchan_e               out_chan;
    logic                 blk_done;
    logic signed [DW:0]   mean_ref, mean_adj, mav_ref, mav_adj;

    ilv_corrector #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_cor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .off_est(off_est), .gain_est(gain_est),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
    );

    ilv_stats #(.DW(DW), .LOG2_BLK(LOG2_BLK)) u_stats (
        .clk(clk), .rst_n(rst_n), .s_valid(out_valid), .s_chan(out_chan),
        .s_data(out_data), .blk_done(blk_done),
        .mean_ref(mean_ref), .mean_adj(mean_adj), .mav_ref(mav_ref), .mav_adj(mav_adj)
    );

    ilv_loop #(.DW(DW), .GW(GW), .FRAC(FRAC), .SHW(SHW)) u_loop (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en),
        .off_shift(off_shift), .gain_shift(gain_shift), .blk_done(blk_done),
        .mean_ref(mean_ref), .mean_adj(mean_adj), .mav_ref(mav_ref), .mav_adj(mav_adj),
        .off_est(off_est), .gain_est(gain_est)
    );
endmodule

// File: tb/ilv_mismatch_cal_tb_top.sv
`timescale 1ns/1ps
module ilv_mismatch_cal_tb_top;
    localparam int DW = 12, GW = 14, FRAC = 12, L2 = 3, SHW = 4;
    localparam int NB = 1 << L2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_en = 1'b0;
    logic [SHW-1:0] off_shift = '0, gain_shift = '0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic out_valid;
    logic signed [DW-1:0] out_data;

    always #10 clk = ~clk;

    ilv_mismatch_cal #(.DW(DW), .GW(GW), .FRAC(FRAC), .LOG2_BLK(L2), .SHW(SHW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .off_shift(off_shift),
        .gain_shift(gain_shift), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0, n_fail = 0;
    string cur_tag = "R2";
    bit finished = 0;

    // behavioural reference model
    int m_tog, m_outv, m_out, m_ch, m_cnt, m_sref, m_sadj, m_aref, m_aadj, m_off, m_gain;

    function automatic int iabs(int v); return (v < 0) ? -v : v; endfunction
    function automatic int clampi(int v, int lo, int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    always @(posedge clk) begin : model
        int n_off, n_gain, x, y;
        if (!rst_n) begin
            m_tog = 0; m_outv = 0; m_out = 0; m_ch = 0; m_cnt = 0;
            m_sref = 0; m_sadj = 0; m_aref = 0; m_aadj = 0;
            m_off = 0; m_gain = 1 << FRAC;
        end else begin
            n_off = m_off; n_gain = m_gain;
            if (m_outv != 0) begin
                if (m_ch == 0) begin
                    m_sref += m_out; m_aref += iabs(m_out);
                end else begin
                    m_sadj += m_out; m_aadj += iabs(m_out);
                    if (m_cnt == NB - 1) begin
                        if (cal_en) begin
                            n_off  = clampi(m_off + (((m_sadj >>> L2) - (m_sref >>> L2)) >>> off_shift), -2048, 2047);
                            n_gain = clampi(m_gain + (((m_aref >>> L2) - (m_aadj >>> L2)) >>> gain_shift), 0, (1 << GW) - 1);
                        end
                        m_sref = 0; m_sadj = 0; m_aref = 0; m_aadj = 0; m_cnt = 0;
                    end else m_cnt++;
                end
            end
            if (in_valid) begin
                x = in_data;
                if (m_tog != 0) begin
                    y = ((x - m_off) * m_gain + (1 << (FRAC - 1))) >>> FRAC;
                    m_out = clampi(y, -2048, 2047);
                end else m_out = x;
                m_ch = m_tog; m_outv = 1; m_tog = 1 - m_tog;
            end else m_outv = 0;
            m_off = n_off; m_gain = n_gain;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_chk++;
            if (out_valid !== m_outv[0]) begin
                n_fail++;
                $display("FAIL R2: out_valid=%0d expected %0d", out_valid, m_outv);
            end else if (out_valid && int'(out_data) != m_out) begin
                n_fail++;
                $display("FAIL %s: out_data=%0d expected %0d", (m_ch == 0) ? "R3" : cur_tag, out_data, m_out);
            end
        end
    end

    task automatic check(string tag, int act, int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic check_near(string tag, int act, int exp_v, int tol);
        n_chk++;
        if (iabs(act - exp_v) > tol) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (+/-%0d)", tag, act, exp_v, tol);
        end
    endtask

    task automatic send(int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(v);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // send one pair and return the adjusted channel's output
    task automatic probe(int a, int b, output int y);
        send(a);
        send(b);
        @(negedge clk);
        in_valid = 1'b0;
        y = out_data;
    endtask

    function automatic int wave(int i);
        return ((i * 37) % 801) - 400;
    endfunction

    task automatic finish_up();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin : stim
        int y, p1, p2;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 out_data", out_data, 0);
        rst_n = 1'b1;

        // R1: zero offset and unity gain leave adjusted samples unchanged
        cur_tag = "R1";
        probe(300, -700, y);
        check("R1 unity", y, -700);
        probe(-5, 2047, y);
        check("R1 unity top", y, 2047);

        // R2: gaps inside and between pairs do not advance the index
        cur_tag = "R2";
        send(11); idle(3); send(-13); idle(2);
        check("R2 gap pair", out_data, -13);
        send(50); idle(1); send(60); idle(1);

        // R6 and R9: offset loop pulls +20 out of the adjusted channel
        cur_tag = "R6";
        off_shift = 4'd1; gain_shift = 4'd0; cal_en = 1'b1;
        for (int i = 0; i < 40 * NB; i++) begin
            send(wave(i));
            send(wave(i) + 20);
        end
        cur_tag = "R9";
        probe(200, 220, y);
        check_near("R6 offset converged", y, 200, 2);

        // R8: frozen estimates survive a large mismatch
        cal_en = 1'b0;
        cur_tag = "R8";
        probe(100, 120, p1);
        for (int i = 0; i < 3 * NB - 1; i++) begin
            send(wave(i + 7));
            send(wave(i + 7) - 300);
        end
        probe(100, 120, p2);
        check("R8 frozen", p2, p1);

        // R4: positive offset estimate drives a negative full-scale sample into saturation
        cur_tag = "R4";
        probe(0, -2048, y);
        check("R4 saturation", y, -2048);

        // R7 and R5: gain loop removes a 5/4 gain error
        cur_tag = "R7";
        cal_en = 1'b1;
        for (int i = 0; i < 120 * NB; i++) begin
            send(wave(i));
            send((wave(i) * 5) / 4 + 20);
        end
        cur_tag = "R5";
        probe(400, 520, y);
        check_near("R7 gain converged", y, 400, 6);
        probe(-320, -380, y);
        check_near("R7 gain negative", y, -320, 6);
        idle(4);
        finish_up();
    end
endmodule